// File: doc/BRIEF.md
# Resolver Angle Tracking Loop

This block turns a stream of digitized resolver signals into a shaft angle and a shaft speed. Each time `sample_en` is high it takes one signed sine sample and one signed cosine sample of the true angle. It compares them with a sine/cosine of its own angle estimate to form an error proportional to the sine of the angle difference. It then advances two cascaded accumulators. The first accumulator integrates the scaled error into a velocity. A first-order lead/lag section with a zero just below one and a pole a little lower shapes that velocity. The second accumulator integrates the shaped velocity into a wrapping angle.

Because two integrators sit in the loop, a shaft turning at constant speed is followed with no standing angle error. The lead/lag section supplies the phase margin. The angle comes out as a 12-bit word over one full turn. The speed comes out as a 12-bit signed word that clips at its limits. The sample enable is the loop's update clock, so the host decides the update rate.

Top module: `resolver_track_loop`

## Requirements
- R1: A synchronous reset clears the angle accumulator, the velocity accumulator and both lead/lag history registers to zero, so `pos_out` and `vel_out` read 0 on the cycle after reset.
- R2: On a clock edge where `sample_en` is low, no state changes and the values on `sin_in`/`cos_in` have no effect, so `pos_out` and `vel_out` hold.
- R3: On each enabled edge the velocity accumulator (32-bit two's complement) adds `(sin_in*C - cos_in*S) >>> 13`. S and C are the Q14 sine and cosine of the current estimate, and the shift is arithmetic.
- R4: S and C come from the top 14 bits of the angle accumulator. The top 2 bits select the quadrant and the low 12 bits give the fraction r. The quarter is folded as x=r in quadrants 0 and 2 and x=4096-r in quadrants 1 and 3. The value is taken as x2=x*x>>12, then m=((51472-((21076-(2372*x2>>12))*x2>>12))*x)>>13, and it is negated in quadrants 2 and 3. C uses the phase plus 4096.
- R5: The lead/lag output is y = v - (vp - (vp>>>12)) + (yp - 11*(yp>>>12)). Here v is the velocity accumulator before the edge, vp is its value one enabled sample earlier, and yp is the previous output. This realises a zero at 4095/4096 and a pole at 4085/4096.
- R6: On each enabled edge the angle accumulator adds y modulo 2^32, and `pos_out` is its bits [31:20].
- R7: `vel_out` is the velocity accumulator shifted right arithmetically by 9 and clipped to the range -2048 to 2047.
- R8: With sine/cosine inputs of a constant-speed angle ramp in either direction, the loop settles so that `pos_out` stays within ±2 LSB of the input angle (mod 4096), including across the 4095-to-0 wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | One loop update on each edge where this is high |
| sin_in | input | 12 | Signed sine sample of the shaft angle |
| cos_in | input | 12 | Signed cosine sample of the shaft angle |
| pos_out | output | 12 | Angle estimate, one full turn over 4096 codes |
| vel_out | output | 12 | Signed velocity estimate, clipped |

## Verification
A slow forward ramp that starts 30 degrees away from the reset angle shows acquisition and the zero standing error of the double integrator. A faster forward ramp and then a fast reverse ramp drive the velocity word into its positive and negative clip limits. The reverse ramp also forces a large speed step, which reveals a wrong sign or coefficient in the lead/lag. Hold windows with junk on the inputs separate a loop that gates on `sample_en` from one that does not. A final reset pulse issued with the enable high shows that reset wins over an update. Because the bench compares bit for bit on every clock, any slip in the quadrant fold, the shift amounts or the wrap shows up on the first sample that exercises it.

// File: rtl/resolver_pkg.sv
package resolver_pkg;

  // common accumulator width for velocity, compensator and angle
  localparam int ACC_W  = 32;
  // Q14 trig words need 16 signed bits to hold +/-16384
  localparam int TRIG_W = 16;

  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic signed [TRIG_W-1:0] trig_t;

  // Q15 coefficients of the odd quintic for sin(pi/2 * x), x in [0,1].
  // They are chosen so that A - B + C == 32768 (exact unity at 90 degrees).
  localparam logic [63:0] POLY_A = 64'd51472;
  localparam logic [63:0] POLY_B = 64'd21076;
  localparam logic [63:0] POLY_C = 64'd2372;

  // quarter-wave value, x in Q(qb) from 0 to 1.0, result in Q14
  function automatic trig_t quarter_poly(input logic [63:0] x, input int qb);
    logic [63:0] x2, t1, t2, t3, t4, y;
    x2 = (x * x) >> qb;
    t1 = (POLY_C * x2) >> qb;
    t2 = POLY_B - t1;
    t3 = (t2 * x2) >> qb;
    t4 = POLY_A - t3;
    y  = (t4 * x) >> (qb + 1);
    return trig_t'(y);
  endfunction

  // full-turn sine of a pw-bit phase by quadrant folding
  function automatic trig_t phase_sine(input logic [63:0] ph, input int pw);
    int          qb;
    logic [1:0]  quad;
    logic [63:0] r, x;
    trig_t       m;
    qb   = pw - 2;
    quad = 2'(ph >> qb);
    r    = ph & ((64'd1 << qb) - 64'd1);
    x    = quad[0] ? ((64'd1 << qb) - r) : r;
    m    = quarter_poly(x, qb);
    return quad[1] ? -m : m;
  endfunction

  // a*x with a = 1 - 2^-sh
  function automatic acc_t zero_term(input acc_t x, input int sh);
    return x - (x >>> sh);
  endfunction

  // b*y with b = 1 - mult*2^-sh
  function automatic acc_t pole_term(input acc_t y, input int sh, input int mult);
    return y - (y >>> sh) * acc_t'(mult);
  endfunction

endpackage

// File: rtl/res_trig_lookup.sv
module res_trig_lookup
  import resolver_pkg::*;
#(
  parameter int PHASE_W = 14
) (
  input  logic [PHASE_W-1:0] phase,
  output trig_t              sin_val,
  output trig_t              cos_val
);
  localparam int QB = PHASE_W - 2;

  trig_t vals [2];

  // channel 0 is the sine; channel 1 is the same curve a quarter turn ahead
  generate
    for (genvar g = 0; g < 2; g++) begin : g_chan
      localparam logic [PHASE_W-1:0] OFS = PHASE_W'(g) << QB;
      logic [PHASE_W-1:0] ph_g;
      assign ph_g    = phase + OFS;
      assign vals[g] = phase_sine(64'(ph_g), PHASE_W);
    end
  endgenerate

  assign sin_val = vals[0];
  assign cos_val = vals[1];
endmodule

// File: rtl/res_phase_detector.sv
module res_phase_detector
  import resolver_pkg::*;
#(
  parameter int IN_W      = 12,
  parameter int ERR_SHIFT = 13
) (
  input  logic signed [IN_W-1:0] sin_in,
  input  logic signed [IN_W-1:0] cos_in,
  input  trig_t                  sin_est,
  input  trig_t                  cos_est,
  output acc_t                   err_scaled
);
  localparam int PROD_W = IN_W + TRIG_W;
  localparam int ERR_W  = PROD_W + 1;

  logic signed [PROD_W-1:0] p_sc, p_cs;
  logic signed [ERR_W-1:0]  err_raw;

  // sin(in - est) = sin_in*cos_est - cos_in*sin_est, kept at full precision
  always_comb begin
    p_sc       = PROD_W'(sin_in) * PROD_W'(cos_est);
    p_cs       = PROD_W'(cos_in) * PROD_W'(sin_est);
    err_raw    = ERR_W'(p_sc) - ERR_W'(p_cs);
    err_scaled = ACC_W'(err_raw >>> ERR_SHIFT);
  end
endmodule

// File: rtl/res_lead_lag.sv
module res_lead_lag
  import resolver_pkg::*;
#(
  parameter int CMP_SHIFT = 12,
  parameter int POLE_MULT = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  acc_t x_in,
  output acc_t y_next
);
  acc_t x_prev, y_prev;

  // y[n] = x[n] - a*x[n-1] + b*y[n-1]
  assign y_next = x_in - zero_term(x_prev, CMP_SHIFT)
                + pole_term(y_prev, CMP_SHIFT, POLE_MULT);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_prev <= '0;
      y_prev <= '0;
    end else if (en) begin
      x_prev <= x_in;
      y_prev <= y_next;
    end
  end
endmodule

// File: rtl/res_accum.sv
module res_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] step,
  output logic [W-1:0] acc_q
);
  // modulo-2^W integrator; signed or unsigned reading is up to the user
  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_q + step;
  end
endmodule

// File: rtl/resolver_track_loop.sv
module resolver_track_loop
  import resolver_pkg::*;
#(
  parameter int IN_W      = 12,
  parameter int PHASE_W   = 14,
  parameter int OUT_W     = 12,
  parameter int VEL_W     = 12,
  parameter int ERR_SHIFT = 13,
  parameter int VEL_SHIFT = 9,
  parameter int CMP_SHIFT = 12,
  parameter int POLE_MULT = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sample_en,
  input  logic signed [IN_W-1:0] sin_in,
  input  logic signed [IN_W-1:0] cos_in,
  output logic [OUT_W-1:0]       pos_out,
  output logic signed [VEL_W-1:0] vel_out
);
  localparam acc_t VEL_MAX = acc_t'((64'sd1 <<< (VEL_W - 1)) - 64'sd1);
  localparam acc_t VEL_MIN = acc_t'(-(64'sd1 <<< (VEL_W - 1)));

  // named internal events, also seen by the bound checker
  logic [ACC_W-1:0] pos_acc;
  acc_t             vel_acc;
  acc_t             err_scaled;
  acc_t             comp_y;
  trig_t            sin_est, cos_est;
  acc_t             vel_shifted;
  logic             vel_sat_hi, vel_sat_lo;

  res_trig_lookup #(.PHASE_W(PHASE_W)) u_trig (
    .phase   (pos_acc[ACC_W-1 -: PHASE_W]),
    .sin_val (sin_est),
    .cos_val (cos_est)
  );

  res_phase_detector #(.IN_W(IN_W), .ERR_SHIFT(ERR_SHIFT)) u_det (
    .sin_in     (sin_in),
    .cos_in     (cos_in),
    .sin_est    (sin_est),
    .cos_est    (cos_est),
    .err_scaled (err_scaled)
  );

  // first integrator: error -> velocity
  res_accum #(.W(ACC_W)) u_vel_int (
    .clk   (clk),
    .rst   (rst),
    .en    (sample_en),
    .step  (err_scaled),
    .acc_q (vel_acc)
  );

  // lead/lag works on the registered velocity
  res_lead_lag #(.CMP_SHIFT(CMP_SHIFT), .POLE_MULT(POLE_MULT)) u_comp (
    .clk    (clk),
    .rst    (rst),
    .en     (sample_en),
    .x_in   (vel_acc),
    .y_next (comp_y)
  );

  // second integrator: shaped velocity -> angle, wraps each turn
  res_accum #(.W(ACC_W)) u_pos_int (
    .clk   (clk),
    .rst   (rst),
    .en    (sample_en),
    .step  (comp_y),
    .acc_q (pos_acc)
  );

  assign pos_out = pos_acc[ACC_W-1 -: OUT_W];

  always_comb begin
    vel_shifted = vel_acc >>> VEL_SHIFT;
    vel_sat_hi  = vel_shifted > VEL_MAX;
    vel_sat_lo  = vel_shifted < VEL_MIN;
    if (vel_sat_hi)      vel_out = VEL_MAX[VEL_W-1:0];
    else if (vel_sat_lo) vel_out = VEL_MIN[VEL_W-1:0];
    else                 vel_out = vel_shifted[VEL_W-1:0];
  end
endmodule

// File: rtl/resolver_track_loop_chk.sv
module resolver_track_loop_chk
  import resolver_pkg::*;
#(
  parameter int OUT_W = 12,
  parameter int VEL_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sample_en,
  input logic [OUT_W-1:0]        pos_out,
  input logic signed [VEL_W-1:0] vel_out,
  input logic [ACC_W-1:0]        pos_acc,
  input acc_t                    vel_acc,
  input acc_t                    err_scaled,
  input acc_t                    comp_y
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: state and outputs read zero after a reset edge
  always @(negedge clk) begin
    if (rst_seen === 1'b1) begin
      assert_reset_clear_R1: assert (pos_acc == '0 && vel_acc == '0 &&
                                     pos_out == '0 && vel_out == '0)
        else $error("reset did not clear the loop state");
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> ($stable(pos_acc) && $stable(vel_acc) &&
                    $stable(pos_out) && $stable(vel_out)))
    else $error("state moved without sample_en");

  assert_vel_int_R3: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> (vel_acc == $past(vel_acc) + $past(err_scaled)))
    else $error("velocity integrator did not add the detector error");

  assert_pos_int_R6: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> (pos_acc == $past(pos_acc) + $past(comp_y)))
    else $error("angle integrator did not add the compensator output");

  assert_vel_sign_R7: assert property (@(posedge clk) disable iff (rst)
    vel_out[VEL_W-1] == vel_acc[ACC_W-1])
    else $error("velocity output sign disagrees with the integrator");
endmodule

bind resolver_track_loop resolver_track_loop_chk #(.OUT_W(OUT_W), .VEL_W(VEL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sample_en  (sample_en),
  .pos_out    (pos_out),
  .vel_out    (vel_out),
  .pos_acc    (pos_acc),
  .vel_acc    (vel_acc),
  .err_scaled (err_scaled),
  .comp_y     (comp_y)
);

// File: tb/test_resolver_track_loop.sv
module test_resolver_track_loop;
  localparam real    PI   = 3.14159265358979323846;
  localparam real    AMP  = 1474.0;
  localparam longint MASK = 64'hFFFF_FFFF;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sample_en = 1'b0;
  logic signed [11:0] sin_in = '0;
  logic signed [11:0] cos_in = '0;
  logic [11:0]        pos_out;
  logic signed [11:0] vel_out;

  resolver_track_loop i_resolver_track_loop (
    .clk(clk), .rst(rst), .sample_en(sample_en),
    .sin_in(sin_in), .cos_in(cos_in),
    .pos_out(pos_out), .vel_out(vel_out)
  );

  always #2ns clk = ~clk;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  // behavioural reference state
  longint pos_m;
  int     vel_m, xp_m, y_m;
  // stimulus angle, 2^32 per turn, and its step per sample
  longint ang;
  longint dstep;

  // R4 restated: folded quarter curve, integer division instead of shifts
  function automatic int ref_sine(input int p);
    int q, r, x;
    longint xx, inner, poly;
    q = p / 4096;
    r = p % 4096;
    x = (q % 2 == 1) ? 4096 - r : r;
    xx = (longint'(x) * x) / 4096;
    inner = 21076 - (2372 * xx) / 4096;
    poly = 51472 - (inner * xx) / 4096;
    ref_sine = int'((poly * x) / 8192);
    if (q >= 2) ref_sine = -ref_sine;
  endfunction

  task automatic ref_step(input int si, input int ci);
    int ph, s_e, c_e, y_new;
    longint err;
    ph  = int'(pos_m >> 18);
    s_e = ref_sine(ph);
    c_e = ref_sine((ph + 4096) % 16384);
    err = longint'(si) * c_e - longint'(ci) * s_e;           // R3
    y_new = vel_m - (xp_m - (xp_m >>> 12)) + (y_m - 11 * (y_m >>> 12)); // R5
    xp_m  = vel_m;
    y_m   = y_new;
    vel_m = vel_m + int'(err >>> 13);
    pos_m = (pos_m + longint'(y_new)) & MASK;                // R6
  endtask

  function automatic int exp_vel();
    int v;
    v = vel_m >>> 9;                                          // R7
    if (v > 2047) v = 2047;
    if (v < -2048) v = -2048;
    return v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic run_cycle(input bit en, input bit junk, input string tag);
    real th;
    th = 2.0 * PI * real'(ang) / 4294967296.0;
    if (junk) begin
      sin_in = 12'sh7FF;
      cos_in = -12'sd2048;
    end else begin
      sin_in = 12'($rtoi($floor(AMP * $sin(th) + 0.5)));
      cos_in = 12'($rtoi($floor(AMP * $cos(th) + 0.5)));
    end
    sample_en = en;
    @(posedge clk);
    if (rst) begin
      pos_m = 0; vel_m = 0; xp_m = 0; y_m = 0;
    end else if (en) begin
      ref_step(int'(sin_in), int'(cos_in));
      ang = (ang + dstep) & MASK;
    end
    @(negedge clk);
    // per-clock comparison covers R3, R4, R5 and R6 through pos, R7 through vel
    chk({tag, " pos"}, int'(pos_out), int'(pos_m >> 20));
    chk({tag, " vel"}, int'(vel_out), exp_vel());
  endtask

  // R8: circular distance between estimate and input angle
  task automatic track_check(input string tag);
    int d;
    d = (int'(pos_out) - int'(ang >> 20)) & 4095;
    if (d >= 2048) d -= 4096;
    n_chk++;
    if (d > 2 || d < -2) begin
      n_fail++;
      $display("FAIL %s tracking actual=%0d expected=%0d (+/-2)", tag, int'(pos_out), int'(ang >> 20));
    end
  endtask

  task automatic run_ramp(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      run_cycle(1'b1, 1'b0, "R6/R7 model");
      if (i >= n - 5000 && i % 500 == 0) track_check(tag);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    pos_m = 0; vel_m = 0; xp_m = 0; y_m = 0;
    ang   = 64'd357913941;   // 30 degrees away from the reset angle
    dstep = 64'd65536;

    // R1: reset state
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 4; i++) run_cycle(1'b0, 1'b0, "R1 reset");
    chk("R1 pos after reset", int'(pos_out), 0);
    chk("R1 vel after reset", int'(vel_out), 0);
    rst = 1'b0;

    // R2: with the enable low and junk inputs the outputs must not move
    for (int i = 0; i < 8; i++) run_cycle(1'b0, 1'b1, "R2 hold at reset");

    // R8: slow forward ramp, acquisition and lock
    run_ramp(30000, "R8 slow forward");
    chk("R7 vel in slow ramp", int'(vel_out >= 1300 && vel_out <= 1500), 1);

    // R2: alternate enable, junk on the inputs while disabled
    for (int i = 0; i < 200; i++) begin
      if (i % 2 == 0) run_cycle(1'b0, 1'b1, "R2 hold");
      else            run_cycle(1'b1, 1'b0, "R2 interleave");
    end

    // R7 positive clip and R8 at higher speed
    dstep = 64'd131072;
    run_ramp(30000, "R8 fast forward");
    chk("R7 positive clip", int'(vel_out), 2047);

    // R7 negative clip and R8 in reverse, crossing the 0/4095 wrap
    dstep = (64'd0 - 64'd131072) & MASK;
    run_ramp(40000, "R8 fast reverse");
    chk("R7 negative clip", int'(vel_out), -2048);

    // R1: reset wins over an active enable
    rst = 1'b1;
    run_cycle(1'b1, 1'b0, "R1 mid reset");
    chk("R1 pos after mid reset", int'(pos_out), 0);
    chk("R1 vel after mid reset", int'(vel_out), 0);
    rst = 1'b0;

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule